// File: doc/BRIEF.md
# Bayer Tile to 4:2:0 Macroblock Converter

This block takes one raw colour-mosaic tile of 20x20 pixels and turns it into one 4:2:0 YCbCr macroblock. The tile is fetched from an external frame buffer, and neighbouring tiles overlap. Each tile holds a two-pixel margin around a central 16x16 area. Only that central area is coded. The margin supplies the neighbours that interpolation needs at the macroblock edge. The tile arrives as a raster stream of 400 pixels. The macroblock leaves as six 8x8 blocks, 384 samples in all, one sample per output beat.

A three-state machine drives the block. In `S_LOAD` it writes incoming pixels into a tile store, and leaves for `S_LUMA` once the 400th pixel has been accepted. `S_LUMA` takes 256 cycles. In each cycle it demosaics one pixel of the central area, converts it to luma and emits the result. It then moves to `S_CHROMA`, which runs 512 cycles. There it visits every 2x2 pixel group once for Cb and once for Cr, accumulating four converted values and emitting their rounded mean. After the last Cr sample it returns to `S_LOAD`. While the machine is outside `S_LOAD`, input is refused.

Top module: `bayer_mb_conv`

## Requirements
- R1: After reset, `out_valid` and `out_last` are 0 and `in_ready` is 1.
- R2: A pixel is accepted in any cycle where `in_valid` and `in_ready` are both high. Accepted pixels fill the tile in raster order, index = row*20 + column. `in_ready` stays high through the first 399 pixels and drops in the cycle after the 400th is accepted. It then stays low until the end of the macroblock, and no output appears before the 400th pixel.
- R3: `in_valid` and `in_pix` have no effect while `in_ready` is low. The next tile's output depends only on the pixels accepted for that tile.
- R4: Each tile yields exactly 384 output beats. `out_blk` is 0,1,2,3 for the luma blocks Y0..Y3, 4 for Cb and 5 for Cr, in that order, with 64 beats per block in raster order. `out_last` is high only on the 384th beat.
- R5: Luma block k covers macroblock rows 8*k[1]..8*k[1]+7 and columns 8*k[0]..8*k[0]+7. Macroblock pixel (r,c) is tile pixel (r+2,c+2).
- R6: The mosaic has red at even row and even column, blue at odd row and odd column, and green elsewhere. Parity is counted in tile coordinates.
- R7: Missing colours are bilinear. At a red or blue site, green is the rounded mean of the four edge neighbours, (a+b+c+d+2)>>2, and the opposite colour is the rounded mean of the four diagonal neighbours. At a green site, the colour that lies along its own row is the mean of left and right, and the other is the mean of up and down, each computed as (a+b+1)>>1.
- R8: Y = ((66R + 129G + 25B + 128) >> 8) + 16. Every luma sample lies in 16..235.
- R9: Cb = ((-38R - 74G + 112B + 128) >>> 8) + 128 and Cr = ((112R - 94G - 18B + 128) >>> 8) + 128, both using an arithmetic shift. Every chroma sample lies in 16..240.
- R10: Chroma sample (i,j) is (s+2)>>2, where s is the sum of the per-pixel values over macroblock pixels (2i..2i+1, 2j..2j+1).
- R11: `in_ready` is already high in the cycle where `out_last` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Raw pixel present |
| in_pix | input | 8 | Raw mosaic pixel |
| in_ready | output | 1 | Block is loading a tile |
| out_valid | output | 1 | Output sample present |
| out_blk | output | 3 | Block index: 0..3 luma, 4 Cb, 5 Cr |
| out_sample | output | 8 | Output sample |
| out_last | output | 1 | Final sample of the macroblock |

## Verification
Several input patterns are used, and each one isolates a different part of the block:
- A flat grey tile and the all-zero and all-full tiles pin the offsets, the luma range limits and neutral chroma.
- A tile lit only at red sites, and another lit only at blue sites, checks the mosaic phase. If the phase were swapped or shifted, luma and both chroma values would all change.
- Pseudo-random tiles are compared sample by sample against an independent model. These catch errors in quadrant mapping, neighbour selection, rounding and 2x2 grouping.
- A split load and a run with junk input during output check the accept count and that refused input is ignored.

// File: rtl/bmc_pkg.sv
package bmc_pkg;

    localparam int PIX_W = 8;

    typedef logic [PIX_W-1:0] pix_t;

    typedef enum logic [1:0] {
        S_LOAD   = 2'd0,
        S_LUMA   = 2'd1,
        S_CHROMA = 2'd2
    } state_t;

    function automatic pix_t mean2(input pix_t a, input pix_t b);
        logic [PIX_W:0] s;
        s = {1'b0, a} + {1'b0, b} + {{PIX_W{1'b0}}, 1'b1};
        return s[PIX_W:1];
    endfunction

    function automatic pix_t mean4(input pix_t a, input pix_t b,
                                   input pix_t c, input pix_t d);
        logic [PIX_W+1:0] s;
        s = {2'b00, a} + {2'b00, b} + {2'b00, c} + {2'b00, d}
            + {{PIX_W{1'b0}}, 2'b10};
        return s[PIX_W+1:2];
    endfunction

endpackage

// File: rtl/bmc_tile_buf.sv
module bmc_tile_buf
    import bmc_pkg::*;
#(
    parameter int TILE = 20,
    localparam int DEPTH = TILE * TILE,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(TILE)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [AW-1:0]   waddr,
    input  pix_t            wdata,
    input  logic [CW-1:0]   crow,
    input  logic [CW-1:0]   ccol,
    output pix_t [8:0]      win
);

    pix_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // 3x3 neighbourhood around (crow, ccol); index = 3*dy + dx
    for (genvar dy = 0; dy < 3; dy++) begin : g_row
        for (genvar dx = 0; dx < 3; dx++) begin : g_col
            logic [AW-1:0] ra;
            assign ra = AW'((int'(crow) + dy - 1) * TILE + int'(ccol) + dx - 1);
            assign win[dy*3+dx] = mem[ra];
        end
    end

    // R2: writes never exceed the tile
    p_write_in_tile_r2: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (int'(waddr) < DEPTH));

endmodule

// File: rtl/bmc_demosaic.sv
module bmc_demosaic
    import bmc_pkg::*;
(
    input  pix_t [8:0] win,
    input  logic       odd_row,
    input  logic       odd_col,
    output pix_t       red,
    output pix_t       grn,
    output pix_t       blu
);

    pix_t cross_avg;
    pix_t diag_avg;
    pix_t horiz_avg;
    pix_t vert_avg;

    assign cross_avg = mean4(win[1], win[3], win[5], win[7]);
    assign diag_avg  = mean4(win[0], win[2], win[6], win[8]);
    assign horiz_avg = mean2(win[3], win[5]);
    assign vert_avg  = mean2(win[1], win[7]);

    always_comb begin
        unique case ({odd_row, odd_col})
            2'b00: begin
                red = win[4];
                grn = cross_avg;
                blu = diag_avg;
            end
            2'b01: begin
                red = horiz_avg;
                grn = win[4];
                blu = vert_avg;
            end
            2'b10: begin
                red = vert_avg;
                grn = win[4];
                blu = horiz_avg;
            end
            default: begin
                red = diag_avg;
                grn = cross_avg;
                blu = win[4];
            end
        endcase
    end

endmodule

// File: rtl/bmc_csc.sv
module bmc_csc
    import bmc_pkg::*;
(
    input  pix_t red,
    input  pix_t grn,
    input  pix_t blu,
    output pix_t luma,
    output pix_t cb,
    output pix_t cr
);

    int luma_i;
    int cb_i;
    int cr_i;

    always_comb begin
        luma_i = ((66 * int'(red) + 129 * int'(grn) + 25 * int'(blu) + 128) >>> 8) + 16;
        cb_i   = ((-38 * int'(red) - 74 * int'(grn) + 112 * int'(blu) + 128) >>> 8) + 128;
        cr_i   = ((112 * int'(red) - 94 * int'(grn) - 18 * int'(blu) + 128) >>> 8) + 128;
    end

    assign luma = PIX_W'(luma_i);
    assign cb   = PIX_W'(cb_i);
    assign cr   = PIX_W'(cr_i);

endmodule

// File: rtl/bayer_mb_conv.sv
module bayer_mb_conv
    import bmc_pkg::*;
#(
    parameter int MB_DIM = 16,
    parameter int MARGIN = 2,
    localparam int TILE = MB_DIM + 2 * MARGIN,
    localparam int HALF = MB_DIM / 2,
    localparam int HB = $clog2(HALF),
    localparam int DEPTH = TILE * TILE,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(TILE),
    localparam int CH_W = 2 * HB + 3,
    localparam int CNT_W = (AW > CH_W) ? AW : CH_W,
    localparam int LOAD_LAST = DEPTH - 1,
    localparam int LUMA_LAST = MB_DIM * MB_DIM - 1,
    localparam int CHR_LAST = 2 * HALF * HALF * 4 - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [PIX_W-1:0] in_pix,
    output logic             in_ready,
    output logic             out_valid,
    output logic [2:0]       out_blk,
    output logic [PIX_W-1:0] out_sample,
    output logic             out_last
);

    state_t             state, state_n;
    logic [CNT_W-1:0]   cnt, cnt_n;
    logic [PIX_W+1:0]   acc;

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_LOAD;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        unique case (state)
            S_LOAD: begin
                if (in_valid) begin
                    if (cnt == CNT_W'(LOAD_LAST)) begin
                        state_n = S_LUMA;
                        cnt_n   = '0;
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
            end
            S_LUMA: begin
                if (cnt == CNT_W'(LUMA_LAST)) begin
                    state_n = S_CHROMA;
                    cnt_n   = '0;
                end else begin
                    cnt_n = cnt + 1'b1;
                end
            end
            S_CHROMA: begin
                if (cnt == CNT_W'(CHR_LAST)) begin
                    state_n = S_LOAD;
                    cnt_n   = '0;
                end else begin
                    cnt_n = cnt + 1'b1;
                end
            end
            default: begin
                state_n = S_LOAD;
                cnt_n   = '0;
            end
        endcase
    end

    assign in_ready = (state == S_LOAD);

    // ---------------- pixel addressing ----------------
    // luma count:   {qr, qc, row[HB], col[HB]}
    // chroma count: {sel, i[HB], j[HB], sub[2]}
    logic [HB:0]   mb_row, mb_col;
    logic [1:0]    sub;
    logic          chr_sel;
    logic [CW-1:0] t_row, t_col;

    assign sub     = cnt[1:0];
    assign chr_sel = cnt[2*HB+2];

    always_comb begin
        if (state == S_CHROMA) begin
            mb_row = {cnt[2*HB+1:HB+2], sub[1]};
            mb_col = {cnt[HB+1:2], sub[0]};
        end else begin
            mb_row = {cnt[2*HB+1], cnt[2*HB-1:HB]};
            mb_col = {cnt[2*HB], cnt[HB-1:0]};
        end
    end

    assign t_row = CW'(mb_row) + CW'(MARGIN);
    assign t_col = CW'(mb_col) + CW'(MARGIN);

    // ---------------- datapath ----------------
    pix_t [8:0] win;
    pix_t       px_r, px_g, px_b;
    pix_t       px_y, px_cb, px_cr;
    pix_t       chr_val;
    logic [PIX_W+1:0] chr_sum;

    bmc_tile_buf #(.TILE(TILE)) u_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (in_valid && in_ready),
        .waddr (cnt[AW-1:0]),
        .wdata (in_pix),
        .crow  (t_row),
        .ccol  (t_col),
        .win   (win)
    );

    bmc_demosaic u_dem (
        .win     (win),
        .odd_row (t_row[0]),
        .odd_col (t_col[0]),
        .red     (px_r),
        .grn     (px_g),
        .blu     (px_b)
    );

    bmc_csc u_csc (
        .red  (px_r),
        .grn  (px_g),
        .blu  (px_b),
        .luma (px_y),
        .cb   (px_cb),
        .cr   (px_cr)
    );

    assign chr_val = chr_sel ? px_cr : px_cb;
    assign chr_sum = acc + {2'b00, chr_val} + {{PIX_W{1'b0}}, 2'b10};

    // ---------------- outputs ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_last   <= 1'b0;
            out_blk    <= '0;
            out_sample <= '0;
            acc        <= '0;
        end else begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            unique case (state)
                S_LUMA: begin
                    out_valid  <= 1'b1;
                    out_blk    <= {1'b0, cnt[2*HB+1], cnt[2*HB]};
                    out_sample <= px_y;
                end
                S_CHROMA: begin
                    if (sub == 2'd0) begin
                        acc <= {2'b00, chr_val};
                    end else begin
                        acc <= acc + {2'b00, chr_val};
                    end
                    if (sub == 2'd3) begin
                        out_valid  <= 1'b1;
                        out_blk    <= chr_sel ? 3'd5 : 3'd4;
                        out_sample <= chr_sum[PIX_W+1:2];
                        out_last   <= (cnt == CNT_W'(CHR_LAST));
                    end
                end
                default: ;
            endcase
        end
    end

    // ---------------- assertions ----------------
    // R2: no input is taken while samples are still being emitted
    p_ready_low_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |-> !in_ready);

    // R4: the final beat belongs to the Cr block
    p_last_on_cr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> (out_valid && out_blk == 3'd5));

    // R4: block index never moves backwards between adjacent beats
    p_blk_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |=> (!out_valid || out_blk >= $past(out_blk)));

    // R8: luma within studio range
    p_luma_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_blk < 3'd4) |-> (out_sample >= 8'd16 && out_sample <= 8'd235));

    // R9: chroma within studio range
    p_chroma_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_blk >= 3'd4) |-> (out_sample >= 8'd16 && out_sample <= 8'd240));

    // R11: loading reopens together with the last beat
    p_ready_at_last_r11: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> in_ready);

endmodule

// File: tb/tb_bayer_mb_conv.sv
`timescale 1ns/1ps
module tb_bayer_mb_conv;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_pix = '0;
    logic       in_ready;
    logic       out_valid;
    logic [2:0] out_blk;
    logic [7:0] out_sample;
    logic       out_last;

    always #5 clk = ~clk;

    bayer_mb_conv dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_pix     (in_pix),
        .in_ready   (in_ready),
        .out_valid  (out_valid),
        .out_blk    (out_blk),
        .out_sample (out_sample),
        .out_last   (out_last)
    );

    int n_checks = 0;
    int n_errors = 0;
    int cycles = 0;
    int tile [400];
    int lfsr = 32'h1ACE5;

    int cap_n = 0;
    int cap_s [384];
    int cap_b [384];
    bit cap_l [384];
    bit cap_r [384];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (out_valid) begin
            if (cap_n < 384) begin
                cap_s[cap_n] = int'(out_sample);
                cap_b[cap_n] = int'(out_blk);
                cap_l[cap_n] = out_last;
                cap_r[cap_n] = in_ready;
            end
            cap_n++;
        end
    end

    function automatic int nextrand();
        lfsr = lfsr ^ (lfsr << 13);
        lfsr = lfsr ^ (lfsr >>> 17);
        lfsr = lfsr ^ (lfsr << 5);
        return lfsr & 255;
    endfunction

    // ---------- independent model ----------
    function automatic int px(input int y, input int x);
        return tile[y*20 + x];
    endfunction

    function automatic void rgb(input int y, input int x, output int r, output int g, output int b);
        int cr4, dg4, h2, v2;
        cr4 = (px(y-1,x) + px(y+1,x) + px(y,x-1) + px(y,x+1) + 2) / 4;
        dg4 = (px(y-1,x-1) + px(y-1,x+1) + px(y+1,x-1) + px(y+1,x+1) + 2) / 4;
        h2  = (px(y,x-1) + px(y,x+1) + 1) / 2;
        v2  = (px(y-1,x) + px(y+1,x) + 1) / 2;
        if (y % 2 == 0 && x % 2 == 0) begin r = px(y,x); g = cr4; b = dg4; end
        else if (y % 2 == 0)          begin r = h2; g = px(y,x); b = v2; end
        else if (x % 2 == 0)          begin r = v2; g = px(y,x); b = h2; end
        else                          begin r = dg4; g = cr4; b = px(y,x); end
    endfunction

    function automatic int comp(input int y, input int x, input int which);
        int r, g, b;
        rgb(y, x, r, g, b);
        if (which == 0) return ((66*r + 129*g + 25*b + 128) >>> 8) + 16;
        if (which == 1) return ((-38*r - 74*g + 112*b + 128) >>> 8) + 128;
        return ((112*r - 94*g - 18*b + 128) >>> 8) + 128;
    endfunction

    function automatic int expect_sample(input int k);
        int q, w, row, col, sel, i, j, s;
        if (k < 256) begin
            q = k / 64; w = k % 64;
            row = (q / 2) * 8 + w / 8;
            col = (q % 2) * 8 + w % 8;
            return comp(row + 2, col + 2, 0);
        end
        sel = (k - 256) / 64; w = (k - 256) % 64;
        i = w / 8; j = w % 8;
        s = 0;
        for (int a = 0; a < 2; a++)
            for (int c = 0; c < 2; c++)
                s += comp(2*i + a + 2, 2*j + c + 2, sel + 1);
        return (s + 2) / 4;
    endfunction

    // ---------- stimulus helpers ----------
    task automatic send_range(input int lo, input int hi);
        for (int k = lo; k <= hi; k++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_pix = tile[k][7:0];
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wait_output(input bit junk);
        int guard = 0;
        while (cap_n < 384 && guard < 3000) begin
            @(negedge clk);
            if (junk && cap_n < 380) begin
                in_valid = 1'b1;
                in_pix = 8'(nextrand());
            end else begin
                in_valid = 1'b0;
            end
            guard++;
        end
        in_valid = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic compare_all(input string req);
        check(cap_n == 384, "R4", cap_n, 384);
        for (int k = 0; k < 384; k++) begin
            int e;
            e = expect_sample(k);
            check(cap_s[k] == e, req, cap_s[k], e);
            check(cap_b[k] == ((k < 256) ? k / 64 : 4 + (k - 256) / 64), "R4",
                  cap_b[k], (k < 256) ? k / 64 : 4 + (k - 256) / 64);
            check(cap_l[k] == (k == 383), "R4", int'(cap_l[k]), int'(k == 383));
        end
        check(cap_r[383] == 1'b1, "R11", int'(cap_r[383]), 1);
    endtask

    task automatic run_tile(input bit junk, input string req);
        cap_n = 0;
        send_range(0, 399);
        wait_output(junk);
        compare_all(req);
    endtask

    // ---------- scenarios ----------
    task automatic t_reset();
        @(negedge clk);
        check(out_valid == 1'b0, "R1", int'(out_valid), 0);
        check(out_last == 1'b0, "R1", int'(out_last), 0);
        check(in_ready == 1'b1, "R1", int'(in_ready), 1);
    endtask

    task automatic t_flat();
        for (int k = 0; k < 400; k++) tile[k] = 128;
        run_tile(1'b0, "R7");
        check(cap_s[0] == 126, "R8", cap_s[0], 126);
        check(cap_s[256] == 128, "R9", cap_s[256], 128);
        check(cap_s[383] == 128, "R9", cap_s[383], 128);
    endtask

    task automatic t_extremes();
        for (int k = 0; k < 400; k++) tile[k] = 255;
        run_tile(1'b0, "R8");
        check(cap_s[10] == 235, "R8", cap_s[10], 235);
        for (int k = 0; k < 400; k++) tile[k] = 0;
        run_tile(1'b0, "R8");
        check(cap_s[100] == 16, "R8", cap_s[100], 16);
        check(cap_s[300] == 128, "R9", cap_s[300], 128);
    endtask

    task automatic t_red_sites();
        for (int y = 0; y < 20; y++)
            for (int x = 0; x < 20; x++)
                tile[y*20+x] = (y % 2 == 0 && x % 2 == 0) ? 200 : 0;
        run_tile(1'b0, "R6");
        check(cap_s[0] == 68, "R6", cap_s[0], 68);
        check(cap_s[77] == 68, "R6", cap_s[77], 68);
        check(cap_s[256] == 98, "R6", cap_s[256], 98);
        check(cap_s[320] == 216, "R6", cap_s[320], 216);
    endtask

    task automatic t_blue_sites();
        for (int y = 0; y < 20; y++)
            for (int x = 0; x < 20; x++)
                tile[y*20+x] = (y % 2 == 1 && x % 2 == 1) ? 200 : 0;
        run_tile(1'b0, "R6");
        check(cap_s[5] == 36, "R6", cap_s[5], 36);
        check(cap_s[260] == 216, "R6", cap_s[260], 216);
        check(cap_s[330] == 114, "R6", cap_s[330], 114);
    endtask

    task automatic t_random_split_load();
        for (int k = 0; k < 400; k++) tile[k] = nextrand();
        cap_n = 0;
        send_range(0, 398);
        repeat (3) @(negedge clk);
        check(in_ready == 1'b1, "R2", int'(in_ready), 1);
        check(cap_n == 0, "R2", cap_n, 0);
        send_range(399, 399);
        check(in_ready == 1'b0, "R2", int'(in_ready), 0);
        wait_output(1'b0);
        compare_all("R5");
    endtask

    task automatic t_random_chroma();
        for (int k = 0; k < 400; k++) tile[k] = nextrand();
        run_tile(1'b0, "R10");
    endtask

    task automatic t_ignore_when_busy();
        for (int k = 0; k < 400; k++) tile[k] = nextrand();
        run_tile(1'b1, "R3");
        for (int k = 0; k < 400; k++) tile[k] = nextrand();
        run_tile(1'b0, "R3");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_flat();
        t_extremes();
        t_red_sites();
        t_blue_sites();
        t_random_split_load();
        t_random_chroma();
        t_ignore_when_busy();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule